// File: doc/BRIEF.md
# Memory Protection Region Checker

This block holds the settings of eight address regions and judges every bus access against them in the same cycle. Software programs the regions through a small register interface. Each region is a naturally aligned power-of-two window with its own access permission code, an execute-never flag and eight equal subregions that can be switched off one by one. Memory-type attributes (bufferable, cacheable, shareable, type extension) are stored and read back, but they have no effect on the decision.

The core side presents an address, the privilege level, the access kind and a flag that says the core is running a fault or non-maskable handler. The block answers with a single allow bit, and a low value means the access must fault. Overlapping regions are resolved in favour of the highest-numbered one. Addresses that no region covers fall back to a background rule that depends on privilege and on a control bit.

Top module: `mpc_top`

## Requirements
- R1: Register index 0 is read-only and returns 32'h0000_0800: bit 0 (split instruction/data regions) is 0, bits [15:8] give 8 data regions, bits [23:16] give 0 instruction regions. Register indices 5 to 7 read 0 and writes to them are ignored.
- R2: Register index 1 is the control register. Bit 0 turns checking on, bit 1 keeps checking active inside fault/NMI handlers, and bit 2 lets privileged accesses that hit no region pass. It resets to 0 and reads back bits [2:0].
- R3: Register index 2 holds the region selector in bits [2:0], resets to 0, and picks the region that register indices 3 and 4 read and write.
- R4: A write to register index 3 with bit 4 set first loads bits [2:0] into the selector, then stores bits [31:5] as the base of that region. With bit 4 clear the base goes to the region already selected. A read returns base bits [31:5], 0 in bit 4 and the selector in bits [3:0].
- R5: Register index 4 holds the selected region's attributes: enable bit 0, SIZE [5:1], subregion disables [15:8], B 16, C 17, S 18, TEX [21:19], access permission [26:24], execute-never 28. A read returns the written value ANDed with 32'h173F_FF3F.
- R6: An enabled region spans 2^(SIZE+1) bytes, and any SIZE below 4 counts as 4 (32 bytes). Base bits below log2 of the span are ignored when matching.
- R7: For spans of 256 bytes or more, a 1 in disable bit i removes the i-th eighth of the region. For smaller spans the disable bits are ignored.
- R8: A fetch (access kind 2) that is decided by a region with execute-never set faults.
- R9: When checking is active and no region matches, a privileged access passes only if control bit 2 is set, and an unprivileged access always faults.
- R10: With control bit 0 clear every access passes. With the handler flag high and control bit 1 clear every access passes as well.
- R11: When several enabled regions match, the highest-numbered one decides.
- R12: Access kinds are 0 read, 1 write, 2 fetch and 3 read. Fetches need read rights. Permission codes: 0 none; 1 privileged read/write only; 2 privileged read/write, unprivileged read; 3 full; 4 none; 5 privileged read only; 6 and 7 read only for both levels.
- R13: The allow output is combinational from the access inputs and the stored settings. A register write takes effect from the cycle after the clock edge that captures it, so an access presented in the same cycle as the write is judged on the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| acc_addr | input | 32 | Address of the access being checked |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_handler | input | 1 | Core is in a fault or non-maskable handler |
| acc_allow | output | 1 | 1 lets the access proceed, 0 means fault |

## Verification
Reconfiguration and checking can fall in the same cycle: a write strobe that rewrites a region's attributes can be present while an access to that region is being judged. The bench provokes this by driving both in one cycle, with a write that revokes all rights from a region that currently grants full access. The output sampled in that cycle must still allow the access, and the output sampled one cycle later must fault it. The random phase mixes reprogramming with accesses aimed inside, at the edges of and outside the configured regions, and every result is compared against a bench model built from address ranges.

// File: rtl/mpc_pkg.sv
// Package: shared types and constants for the memory protection checker.
// Assumes a 32-bit address space and a register window of eight indices.
package mpc_pkg;

    localparam logic [2:0] RIX_TYPE = 3'd0;
    localparam logic [2:0] RIX_CTRL = 3'd1;
    localparam logic [2:0] RIX_SEL  = 3'd2;
    localparam logic [2:0] RIX_BASE = 3'd3;
    localparam logic [2:0] RIX_ATTR = 3'd4;

    localparam logic [31:0] ATTR_KEEP = 32'h173F_FF3F;
    localparam logic [4:0]  SIZE_MIN  = 5'd4;
    localparam logic [5:0]  SUB_MIN_LOG2 = 6'd8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic       priv_dflt;
        logic       keep_in_handler;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic [26:0] base;
        logic        en;
        logic [4:0]  size;
        logic [7:0]  srd;
        logic        b;
        logic        c;
        logic        s;
        logic [2:0]  tex;
        logic [2:0]  ap;
        logic        xn;
    } region_cfg_t;

    // Returns 1 when the permission code grants the access.
    function automatic logic ap_permits(input logic [2:0] ap, input logic priv,
                                        input logic is_write);
        logic ok;
        case (ap)
            3'd1:       ok = priv;
            3'd2:       ok = priv | ~is_write;
            3'd3:       ok = 1'b1;
            3'd5:       ok = priv & ~is_write;
            3'd6, 3'd7: ok = ~is_write;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mpc_regs.sv
// Module: register file of the checker. Holds control, region selector and
// the per-region settings; provides a combinational read port.
// Assumes NUM_REGIONS is a power of two between 2 and 16.
module mpc_regs
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [2:0]                    reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output ctrl_t                         ctrl,
    output region_cfg_t [NUM_REGIONS-1:0] cfgs
);

    localparam int SEL_W = $clog2(NUM_REGIONS);
    localparam logic [31:0] TYPE_VAL = {16'd0, 8'(NUM_REGIONS), 8'd0};

    logic [SEL_W-1:0]              sel_q;
    ctrl_t                         ctrl_q;
    region_cfg_t [NUM_REGIONS-1:0] cfg_q;
    logic                          base_valid;
    logic [SEL_W-1:0]              base_tgt;
    region_cfg_t                   cur;

    // Target region of a base write: the embedded field or the selector.
    always_comb begin
        base_valid = reg_wdata[4];
        base_tgt   = base_valid ? reg_wdata[SEL_W-1:0] : sel_q;
    end

    // Register updates on writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= '0;
            cfg_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RIX_CTRL: ctrl_q <= ctrl_t'(reg_wdata[2:0]);
                RIX_SEL:  sel_q  <= reg_wdata[SEL_W-1:0];
                RIX_BASE: begin
                    cfg_q[base_tgt].base <= reg_wdata[31:5];
                    if (base_valid) sel_q <= reg_wdata[SEL_W-1:0];
                end
                RIX_ATTR: begin
                    cfg_q[sel_q].en   <= reg_wdata[0];
                    cfg_q[sel_q].size <= reg_wdata[5:1];
                    cfg_q[sel_q].srd  <= reg_wdata[15:8];
                    cfg_q[sel_q].b    <= reg_wdata[16];
                    cfg_q[sel_q].c    <= reg_wdata[17];
                    cfg_q[sel_q].s    <= reg_wdata[18];
                    cfg_q[sel_q].tex  <= reg_wdata[21:19];
                    cfg_q[sel_q].ap   <= reg_wdata[26:24];
                    cfg_q[sel_q].xn   <= reg_wdata[28];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer of the register window.
    always_comb begin
        cur = cfg_q[sel_q];
        case (reg_addr)
            RIX_TYPE: reg_rdata = TYPE_VAL;
            RIX_CTRL: reg_rdata = {29'd0, ctrl_q};
            RIX_SEL:  reg_rdata = 32'(sel_q);
            RIX_BASE: reg_rdata = {cur.base, 1'b0, 4'(sel_q)};
            RIX_ATTR: reg_rdata = {3'd0, cur.xn, 1'b0, cur.ap, 2'd0, cur.tex,
                                   cur.s, cur.c, cur.b, cur.srd, 2'd0,
                                   cur.size, cur.en};
            default:  reg_rdata = 32'd0;
        endcase
    end

    assign ctrl = ctrl_q;
    assign cfgs = cfg_q;

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RIX_CTRL) |=> (ctrl_q == $past(reg_wdata[2:0])));

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr) |=> $stable(ctrl_q));

    p_valid_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RIX_BASE && reg_wdata[4])
        |=> (sel_q == $past(reg_wdata[SEL_W-1:0])));

    p_attr_rdback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RIX_ATTR)
        |=> (reg_addr != RIX_ATTR || reg_rdata == ($past(reg_wdata) & ATTR_KEEP)));

endmodule

// File: rtl/mpc_region_match.sv
// Module: decides whether one address falls inside one region, applying
// the size floor, base masking and subregion disables. Pure combinational.
module mpc_region_match
    import mpc_pkg::*;
(
    input  region_cfg_t cfg,
    input  logic [31:0] addr,
    output logic        hit
);

    logic [4:0]  size_eff;
    logic [5:0]  span_log2;
    logic [32:0] diff;
    logic        in_span;
    logic [31:0] sub_shift;
    logic [2:0]  sub_idx;
    logic        sub_off;

    // Span of the region and position of the address inside it.
    always_comb begin
        size_eff  = (cfg.size < SIZE_MIN) ? SIZE_MIN : cfg.size;
        span_log2 = {1'b0, size_eff} + 6'd1;
        diff      = {1'b0, addr ^ {cfg.base, 5'd0}};
        in_span   = ((diff >> span_log2) == 33'd0);
        sub_shift = addr >> (span_log2 - 6'd3);
        sub_idx   = sub_shift[2:0];
        sub_off   = (span_log2 >= SUB_MIN_LOG2) && cfg.srd[sub_idx];
        hit       = cfg.en && in_span && !sub_off;
    end

endmodule

// File: rtl/mpc_decide.sv
// Module: picks the highest-numbered hitting region and turns its rights,
// the background rule and the bypass conditions into one allow bit.
module mpc_decide
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  ctrl_t                         ctrl,
    input  region_cfg_t [NUM_REGIONS-1:0] cfgs,
    input  logic [NUM_REGIONS-1:0]        hits,
    input  logic                          priv,
    input  acc_kind_e                     kind,
    input  logic                          handler,
    output logic                          allow
);

    localparam int SEL_W = $clog2(NUM_REGIONS);

    logic             win_hit;
    logic [SEL_W-1:0] win_idx;
    region_cfg_t      win;
    logic             active;
    logic             is_write;
    logic             is_fetch;

    // Priority pick: later (higher) indices override earlier ones.
    always_comb begin
        win_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                win_hit = 1'b1;
                win_idx = SEL_W'(i);
            end
        end
        win = cfgs[win_idx];
    end

    // Final verdict from bypass, background rule and region rights.
    always_comb begin
        active   = ctrl.enable && !(handler && !ctrl.keep_in_handler);
        is_write = (kind == ACC_WRITE);
        is_fetch = (kind == ACC_FETCH);
        if (!active)
            allow = 1'b1;
        else if (!win_hit)
            allow = priv && ctrl.priv_dflt;
        else
            allow = ap_permits(win.ap, priv, is_write) && !(is_fetch && win.xn);
    end

    p_xn_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && win_hit && win.xn && kind == ACC_FETCH) |-> !allow);

    p_unpriv_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && !handler && hits == '0 && !priv) |-> !allow);

    p_no_rights_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (active && win_hit && (win.ap == 3'd0 || win.ap == 3'd4)) |-> !allow);

endmodule

// File: rtl/mpc_top.sv
// Module: top of the memory protection region checker. Connects the
// register file, one matcher per region and the decision stage.
// Assumes accesses are judged in the cycle they are presented.
module mpc_top
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_priv,
    input  logic [1:0]  acc_kind,
    input  logic        acc_handler,
    output logic        acc_allow
);

    ctrl_t                         ctrl;
    region_cfg_t [NUM_REGIONS-1:0] cfgs;
    logic [NUM_REGIONS-1:0]        hits;
    acc_kind_e                     kind;

    assign kind = acc_kind_e'(acc_kind);

    mpc_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl),
        .cfgs      (cfgs)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        mpc_region_match u_match (
            .cfg  (cfgs[g]),
            .addr (acc_addr),
            .hit  (hits[g])
        );
    end

    mpc_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl),
        .cfgs    (cfgs),
        .hits    (hits),
        .priv    (acc_priv),
        .kind    (kind),
        .handler (acc_handler),
        .allow   (acc_allow)
    );

    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.enable) |-> acc_allow);

    p_handler_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_handler && !ctrl.keep_in_handler) |-> acc_allow);

endmodule

// File: tb/tb_mpc_top.sv
module tb_mpc_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = 32'd0;
    logic        acc_priv = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic        acc_handler = 1'b0;
    logic        acc_allow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the programmed state
    logic [2:0]  m_ctrl;
    logic [2:0]  m_sel;
    logic [31:0] m_base [8];
    logic [31:0] m_attr [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpc_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
        .acc_priv(acc_priv), .acc_kind(acc_kind), .acc_handler(acc_handler),
        .acc_allow(acc_allow)
    );

    function automatic void model_reset();
        m_ctrl = 3'd0;
        m_sel = 3'd0;
        for (int i = 0; i < 8; i++) begin
            m_base[i] = 32'd0;
            m_attr[i] = 32'd0;
        end
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [31:0] d);
        case (a)
            3'd1: m_ctrl = d[2:0];
            3'd2: m_sel = d[2:0];
            3'd3: begin
                if (d[4]) m_sel = d[2:0];
                m_base[m_sel] = d & 32'hFFFF_FFE0;
            end
            3'd4: m_attr[m_sel] = d & 32'h173F_FF3F;
            default: ;
        endcase
    endfunction

    function automatic int span_log2(input int r);
        int sz = int'(m_attr[r][5:1]);
        if (sz < 4) sz = 4;
        return sz + 1;
    endfunction

    function automatic bit rights(input int ap, input bit priv, input bit wr);
        case (ap)
            0, 4: return 0;
            1: return priv;
            2: return priv || !wr;
            3: return 1;
            5: return priv && !wr;
            default: return !wr;
        endcase
    endfunction

    // expected verdict from address ranges
    function automatic bit expect_allow(input logic [31:0] a, input bit priv,
                                        input logic [1:0] kind, input bit hnd);
        int win = -1;
        if (!m_ctrl[0]) return 1;
        if (hnd && !m_ctrl[1]) return 1;
        for (int r = 0; r < 8; r++) begin
            longint unsigned sz, st, a64, subsz, idx;
            int n = span_log2(r);
            if (!m_attr[r][0]) continue;
            sz = 64'd1 << n;
            st = {32'd0, m_base[r]} & ~(sz - 1);
            a64 = {32'd0, a};
            if (a64 < st || a64 >= st + sz) continue;
            subsz = sz >> 3;
            idx = (a64 - st) / subsz;
            if (n >= 8 && m_attr[r][8 + int'(idx)]) continue;
            win = r;
        end
        if (win < 0) return priv && m_ctrl[2];
        if (kind == 2'd2 && m_attr[win][28]) return 0;
        return rights(int'(m_attr[win][26:24]), priv, kind == 2'd1);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1 check(reg_rdata, exp, tag);
    endtask

    task automatic acc(input logic [31:0] a, input bit priv, input logic [1:0] k,
                       input bit hnd, input string tag);
        @(negedge clk);
        acc_addr = a; acc_priv = priv; acc_kind = k; acc_handler = hnd;
        #1 check({31'd0, acc_allow}, {31'd0, expect_allow(a, priv, k, hnd)}, tag);
    endtask

    task automatic set_region(input int r, input logic [31:0] base, input logic [31:0] attr);
        wr(3'd3, (base & 32'hFFFF_FFE0) | 32'h10 | 32'(r));
        wr(3'd4, attr);
    endtask

    function automatic logic [31:0] mk_attr(input int size, input int srd, input int ap,
                                            input bit xn);
        return 32'd1 | (32'(size) << 1) | (32'(srd) << 8) | (32'(ap) << 24) | (32'(xn) << 28);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd13579));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(3'd0, 32'h0000_0800, "R1 type register");
        rd(3'd5, 32'd0, "R1 unused index reads zero");
        rd(3'd1, 32'd0, "R2 control after reset");
        rd(3'd2, 32'd0, "R3 selector after reset");
        acc(32'h1234_5678, 0, 2'd1, 0, "R10 disabled after reset");
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd0, 32'h0000_0800, "R1 type register ignores writes");
        wr(3'd1, 32'hFFFF_FFFE);
        rd(3'd1, 32'h0000_0006, "R2 control readback");

        // attribute and base registers
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 32'h173F_FF3F, "R5 attribute readback mask");
        wr(3'd3, 32'h1234_5675);
        rd(3'd2, 32'd5, "R4 valid field loads selector");
        rd(3'd3, 32'h1234_5665, "R4 base readback");
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h0000_1005);
        rd(3'd3, 32'h0000_1002, "R4 base write with bit 4 clear");
        wr(3'd2, 32'd5);
        rd(3'd3, 32'h1234_5665, "R3 selector picks region");
        rd(3'd4, 32'h0000_0000, "R3 other region attribute untouched");
        for (int r = 0; r < 8; r++) set_region(r, 32'd0, 32'd0);

        // size and base masking
        wr(3'd1, 32'd1);
        set_region(1, 32'h2000_0000, mk_attr(4, 0, 3, 0));
        acc(32'h2000_001F, 0, 2'd0, 0, "R6 last byte of 32B region");
        acc(32'h2000_0020, 1, 2'd0, 0, "R6 first byte past region");
        set_region(1, 32'h2000_0000, mk_attr(2, 0, 3, 0));
        acc(32'h2000_0010, 0, 2'd1, 0, "R6 size below floor");
        set_region(2, 32'h3000_0440, mk_attr(9, 0, 3, 0));
        acc(32'h3000_0400, 0, 2'd0, 0, "R6 base low bits ignored");
        acc(32'h3000_07FF, 0, 2'd0, 0, "R6 top of 1KB region");
        acc(32'h3000_0800, 0, 2'd0, 0, "R6 above 1KB region");

        // subregions
        set_region(3, 32'h4000_0000, mk_attr(7, 8'h04, 3, 0));
        acc(32'h4000_0040, 0, 2'd0, 0, "R7 disabled eighth");
        acc(32'h4000_0020, 0, 2'd0, 0, "R7 enabled eighth");
        set_region(4, 32'h5000_0000, mk_attr(6, 8'hFF, 3, 0));
        acc(32'h5000_0010, 0, 2'd0, 0, "R7 disables ignored on 128B");

        // execute never and priority
        set_region(5, 32'h6000_0000, mk_attr(11, 0, 3, 1));
        acc(32'h6000_0100, 1, 2'd2, 0, "R8 fetch from execute-never");
        acc(32'h6000_0100, 0, 2'd0, 0, "R8 read from execute-never");
        set_region(6, 32'h6000_0000, mk_attr(4, 0, 0, 0));
        set_region(0, 32'h6000_0000, mk_attr(20, 0, 0, 0));
        acc(32'h6000_0000, 1, 2'd0, 0, "R11 higher region denies");
        acc(32'h6000_0020, 1, 2'd0, 0, "R11 middle region over lower");

        // background and bypass
        wr(3'd1, 32'd5);
        acc(32'h7000_0000, 1, 2'd1, 0, "R9 privileged miss with default map");
        acc(32'h7000_0000, 0, 2'd0, 0, "R9 unprivileged miss");
        wr(3'd1, 32'd1);
        acc(32'h7000_0000, 1, 2'd0, 0, "R9 privileged miss without default map");
        acc(32'h7000_0000, 0, 2'd0, 1, "R10 handler bypass");
        wr(3'd1, 32'd3);
        acc(32'h7000_0000, 0, 2'd0, 1, "R10 handler keeps checking");
        wr(3'd1, 32'd0);
        acc(32'h6000_0000, 0, 2'd1, 0, "R10 disabled allows all");
        wr(3'd1, 32'd1);

        // permission codes
        for (int ap = 0; ap < 8; ap++) begin
            set_region(7, 32'h8000_0000, mk_attr(4, 0, ap, 0));
            for (int k = 0; k < 4; k++) begin
                acc(32'h8000_0004, 1, 2'(k), 0, $sformatf("R12 ap=%0d priv kind=%0d", ap, k));
                acc(32'h8000_0004, 0, 2'(k), 0, $sformatf("R12 ap=%0d user kind=%0d", ap, k));
            end
        end

        // write and check in the same cycle
        set_region(7, 32'h8000_0000, mk_attr(4, 0, 3, 0));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = mk_attr(4, 0, 0, 0);
        acc_addr = 32'h8000_0000; acc_priv = 1'b1; acc_kind = 2'd0; acc_handler = 1'b0;
        #1 check({31'd0, acc_allow}, 32'd1, "R13 same-cycle write uses old rights");
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(3'd4, mk_attr(4, 0, 0, 0));
        #1 check({31'd0, acc_allow}, 32'd0, "R13 new rights next cycle");

        // random phase
        for (int round = 0; round < 15; round++) begin
            wr(3'd1, ($urandom_range(0, 4) != 0) ? (32'($urandom) | 32'd1) : 32'($urandom));
            for (int r = 0; r < 8; r++) begin
                int sz = ($urandom_range(0, 9) == 0) ? 31 : int'($urandom_range(2, 14));
                logic [31:0] at = 32'($urandom) & 32'h173F_FF3F;
                at[5:1] = 5'(sz);
                if ($urandom_range(0, 4) != 0) at[0] = 1'b1;
                if ($urandom_range(0, 1) == 0) begin
                    set_region(r, 32'($urandom), at);
                end else begin
                    wr(3'd2, 32'(r));
                    wr(3'd3, 32'($urandom) & 32'hFFFF_FFEF);
                    wr(3'd4, at);
                end
            end
            for (int t = 0; t < 20; t++) begin
                int r = int'($urandom_range(0, 7));
                int n = span_log2(r);
                logic [31:0] st = (n >= 32) ? 32'd0 : (m_base[r] & ~((32'd1 << n) - 32'd1));
                logic [31:0] off = (n >= 32) ? 32'($urandom) : (32'($urandom) & ((32'd1 << n) - 32'd1));
                logic [31:0] a = ($urandom_range(0, 4) == 0) ? 32'($urandom) : st + off;
                acc(a, 1'($urandom), 2'($urandom), ($urandom_range(0, 9) == 0),
                    "R6 R7 R8 R9 R11 R12 random access");
            end
        end

        finish_run();
    end

endmodule